// File: doc/BRIEF.md
# UART Interrupt Source Prioritiser and Identification

This block gathers the interrupt causes of a FIFO-capable UART, masks each with its own enable bit, and picks the most urgent one still active. The choice is published as a 32-bit read-only identification word, and a single interrupt line is raised while any enabled cause is active. Software reads the word to learn which cause to service.

Receive-line errors and modem-line changes are latched until their own status-read strobes clear them. Received data is a level condition. In FIFO mode it is compared with a trigger threshold. In single-register mode it means the receive register holds data. The transmit request is latched when the transmit level enters its request zone. An identification read that currently reports it clears the latch.

A character-timeout counter runs on a character-time tick. It flags a receive FIFO that holds data but has seen no traffic for four character times.

Top module: `irq_ident_unit`

## Requirements
- R1: Priority, highest first: line error, then receive (data available or timeout), then transmit request, then modem change. Only the highest enabled active cause is reported.
- R2: Bits 2:1 give the reported cause: 11 line error, 10 receive data or timeout, 01 transmit request, 00 modem change.
- R3: Bit 0 is 0 while any enabled cause is active and 1 otherwise. `irqOut` is its inverse. Under reset the word reads 0x00000001.
- R4: In FIFO mode a timeout counter counts `charTick` pulses while the receive level is non-zero. It is cleared by `rxPush`, `rxPop`, an empty receive FIFO, or single-register mode. At 4 ticks it signals a timeout, reported as code 10 with bit 3 set. Bit 3 is set only for a timeout, and only when received-data-available is not also active, which takes precedence within the level.
- R5: Bits 7:6 read 11 in FIFO mode and 00 otherwise. Bits 31:8 and 5:4 always read 0.
- R6: Received data is active when `rxLevel >= rxTrigger` in FIFO mode, and when `rxLevel != 0` in single-register mode.
- R7: The transmit condition is `txLevel <= 8` (half of the 16-entry FIFO) in FIFO mode and `txLevel == 0` otherwise. A rising edge of the condition latches a request. The latch clears when the condition drops, or when `idRead` is pulsed while the word reports the transmit code. A new rising edge wins over the clear.
- R8: Any non-zero `rxErrFlags` latches a line error, and `lsrRead` clears it. Any non-zero `modemDelta` latches a modem change, and `msrRead` clears it. A new event in the same cycle as its clear wins.
- R9: Enable bits gate each cause before prioritisation: bit 0 receive, bit 1 transmit, bit 2 line error, bit 3 modem. A disabled cause neither drives `irqOut` nor appears in the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fifoMode | input | 1 | 1 selects FIFO mode |
| irqEnable | input | 4 | Per-cause enables (R9 order) |
| rxErrFlags | input | 5 | Overrun, parity, framing, break, FIFO error pulses |
| lsrRead | input | 1 | Line-status read strobe |
| rxLevel | input | 5 | Receive FIFO fill level |
| rxTrigger | input | 5 | Receive trigger threshold |
| rxPush | input | 1 | A character entered the receive FIFO |
| rxPop | input | 1 | The receive FIFO was read |
| txLevel | input | 5 | Transmit FIFO fill level |
| modemDelta | input | 4 | Modem input change pulses |
| msrRead | input | 1 | Modem-status read strobe |
| charTick | input | 1 | One pulse per character time |
| idRead | input | 1 | Identification word read strobe |
| idReg | output | 32 | Identification word |
| irqOut | output | 1 | Interrupt request, active high |

## Verification
The identification word and `irqOut` are combinational on the registered cause latches and the current level inputs. Level-driven changes (receive threshold, FIFO mode, enables) are therefore visible in the same cycle. Latched causes, clears and the timeout appear one edge after their strobe or fourth tick.

The bench drives inputs just after the falling edge and compares both outputs one time unit later, against a model whose state advances only at the rising edge. Every cycle therefore checks the settled combinational view of the state left by the previous edge.

// File: rtl/irq_ident_pkg.sv
package irq_ident_pkg;

  typedef struct packed {
    logic lineErr;
    logic rxData;
    logic charTimeout;
    logic txReq;
    logic modemChg;
  } irqSrc_t;

  typedef struct packed {
    logic clrLine;
    logic clrModem;
    logic clrTx;
  } ctlStrobe_t;

  localparam int EN_RX    = 0;
  localparam int EN_TX    = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;
  localparam int EN_W     = 4;

  localparam logic [1:0] CODE_LINE  = 2'b11;
  localparam logic [1:0] CODE_RX    = 2'b10;
  localparam logic [1:0] CODE_TX    = 2'b01;
  localparam logic [1:0] CODE_MODEM = 2'b00;

endpackage

// File: rtl/irq_ident_dp.sv
module irq_ident_dp
  import irq_ident_pkg::*;
#(
  parameter int DEPTH         = 16,
  parameter int TIMEOUT_CHARS = 4,
  parameter int ERR_W         = 5,
  parameter int MODEM_W       = 4,
  parameter int LVL_W         = $clog2(DEPTH) + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fifoMode,
  input  logic [ERR_W-1:0]   rxErrFlags,
  input  logic [LVL_W-1:0]   rxLevel,
  input  logic [LVL_W-1:0]   rxTrigger,
  input  logic               rxPush,
  input  logic               rxPop,
  input  logic [LVL_W-1:0]   txLevel,
  input  logic [MODEM_W-1:0] modemDelta,
  input  logic               charTick,
  input  ctlStrobe_t         strobe,
  output irqSrc_t            src
);

  localparam int CNT_W = $clog2(TIMEOUT_CHARS + 1);
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(TIMEOUT_CHARS);
  localparam logic [LVL_W-1:0] TX_HALF   = LVL_W'(DEPTH / 2);
  localparam int STICKY_N = 2;

  logic               rxNonEmpty;
  logic               txCond;
  logic               txPrev;
  logic               txHeld;
  logic [CNT_W-1:0]   idleCnt;
  logic [STICKY_N-1:0] stickySet;
  logic [STICKY_N-1:0] stickyClr;
  logic [STICKY_N-1:0] stickyHeld;

  assign rxNonEmpty = (rxLevel != '0);
  assign txCond     = fifoMode ? (txLevel <= TX_HALF) : (txLevel == '0);

  // character timeout counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (!fifoMode || !rxNonEmpty || rxPush || rxPop) begin
      idleCnt <= '0;
    end else if (charTick && (idleCnt != CNT_LIMIT)) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  // transmit request latch, set on entry into the request zone
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txPrev <= 1'b0;
      txHeld <= 1'b0;
    end else begin
      txPrev <= txCond;
      if (txCond && !txPrev) begin
        txHeld <= 1'b1;
      end else if (!txCond || strobe.clrTx) begin
        txHeld <= 1'b0;
      end
    end
  end

  // sticky status sources: index 0 line error, index 1 modem change
  assign stickySet[0] = |rxErrFlags;
  assign stickyClr[0] = strobe.clrLine;
  assign stickySet[1] = |modemDelta;
  assign stickyClr[1] = strobe.clrModem;

  generate
    for (genvar gi = 0; gi < STICKY_N; gi++) begin : g_sticky
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stickyHeld[gi] <= 1'b0;
        end else if (stickySet[gi]) begin
          stickyHeld[gi] <= 1'b1;
        end else if (stickyClr[gi]) begin
          stickyHeld[gi] <= 1'b0;
        end
      end
    end
  endgenerate

  always_comb begin
    src.lineErr     = stickyHeld[0];
    src.modemChg    = stickyHeld[1];
    src.rxData      = fifoMode ? (rxLevel >= rxTrigger) : rxNonEmpty;
    src.charTimeout = (idleCnt == CNT_LIMIT);
    src.txReq       = txHeld;
  end

endmodule

// File: rtl/irq_ident_ctl.sv
module irq_ident_ctl
  import irq_ident_pkg::*;
(
  input  irqSrc_t          src,
  input  logic [EN_W-1:0]  irqEnable,
  input  logic             fifoMode,
  input  logic             idRead,
  input  logic             lsrRead,
  input  logic             msrRead,
  output ctlStrobe_t       strobe,
  output logic [31:0]      idReg,
  output logic             irqOut
);

  logic       gLine;
  logic       gRx;
  logic       gTx;
  logic       gModem;
  logic [1:0] code;
  logic       toBit;
  logic       pend;

  assign gLine  = src.lineErr & irqEnable[EN_LINE];
  assign gRx    = (src.rxData | src.charTimeout) & irqEnable[EN_RX];
  assign gTx    = src.txReq & irqEnable[EN_TX];
  assign gModem = src.modemChg & irqEnable[EN_MODEM];

  always_comb begin
    code  = CODE_MODEM;
    toBit = 1'b0;
    pend  = 1'b1;
    if (gLine) begin
      code = CODE_LINE;
    end else if (gRx) begin
      code  = CODE_RX;
      toBit = !src.rxData;
    end else if (gTx) begin
      code = CODE_TX;
    end else if (gModem) begin
      code = CODE_MODEM;
    end else begin
      pend = 1'b0;
    end
  end

  always_comb begin
    strobe.clrLine  = lsrRead;
    strobe.clrModem = msrRead;
    strobe.clrTx    = idRead & pend & (code == CODE_TX);
  end

  assign idReg  = {24'h000000, {2{fifoMode}}, 2'b00, toBit, code, ~pend};
  assign irqOut = pend;

endmodule

// File: rtl/irq_ident_unit.sv
module irq_ident_unit
  import irq_ident_pkg::*;
#(
  parameter int DEPTH         = 16,
  parameter int TIMEOUT_CHARS = 4,
  parameter int ERR_W         = 5,
  parameter int MODEM_W       = 4,
  parameter int LVL_W         = $clog2(DEPTH) + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fifoMode,
  input  logic [3:0]         irqEnable,
  input  logic [ERR_W-1:0]   rxErrFlags,
  input  logic               lsrRead,
  input  logic [LVL_W-1:0]   rxLevel,
  input  logic [LVL_W-1:0]   rxTrigger,
  input  logic               rxPush,
  input  logic               rxPop,
  input  logic [LVL_W-1:0]   txLevel,
  input  logic [MODEM_W-1:0] modemDelta,
  input  logic               msrRead,
  input  logic               charTick,
  input  logic               idRead,
  output logic [31:0]        idReg,
  output logic               irqOut
);

  irqSrc_t    src;
  ctlStrobe_t strobe;

  irq_ident_dp #(
    .DEPTH(DEPTH), .TIMEOUT_CHARS(TIMEOUT_CHARS),
    .ERR_W(ERR_W), .MODEM_W(MODEM_W), .LVL_W(LVL_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .fifoMode(fifoMode),
    .rxErrFlags(rxErrFlags), .rxLevel(rxLevel), .rxTrigger(rxTrigger),
    .rxPush(rxPush), .rxPop(rxPop), .txLevel(txLevel),
    .modemDelta(modemDelta), .charTick(charTick),
    .strobe(strobe), .src(src)
  );

  irq_ident_ctl i_ctl (
    .src(src), .irqEnable(irqEnable), .fifoMode(fifoMode),
    .idRead(idRead), .lsrRead(lsrRead), .msrRead(msrRead),
    .strobe(strobe), .idReg(idReg), .irqOut(irqOut)
  );

endmodule

// File: rtl/irq_ident_chk.sv
module irq_ident_chk #(
  parameter int ERR_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             fifoMode,
  input logic [3:0]       irqEnable,
  input logic [ERR_W-1:0] rxErrFlags,
  input logic [31:0]      idReg,
  input logic             irqOut
);

  // R3
  pend_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    idReg[0] == !irqOut);

  // R5
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idReg[31:8] == 24'h0) && (idReg[5:4] == 2'b00));

  // R5
  fifo_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    idReg[7:6] == {2{fifoMode}});

  // R4
  timeout_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    idReg[3] |-> (idReg[2:1] == 2'b10) && fifoMode && !idReg[0]);

  // R1
  line_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqEnable[2] && (rxErrFlags != '0)) |=>
      (!irqEnable[2] || (idReg[3:0] == 4'b0110)));

endmodule

bind irq_ident_unit irq_ident_chk #(.ERR_W(ERR_W)) i_chk (
  .clk(clk), .rstN(rstN), .fifoMode(fifoMode), .irqEnable(irqEnable),
  .rxErrFlags(rxErrFlags), .idReg(idReg), .irqOut(irqOut)
);

// File: tb/test_irq_ident_unit.sv
module test_irq_ident_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fifoMode = 1'b0;
  logic [3:0]  irqEnable = '0;
  logic [4:0]  rxErrFlags = '0;
  logic        lsrRead = 1'b0;
  logic [4:0]  rxLevel = '0;
  logic [4:0]  rxTrigger = 5'd1;
  logic        rxPush = 1'b0;
  logic        rxPop = 1'b0;
  logic [4:0]  txLevel = '0;
  logic [3:0]  modemDelta = '0;
  logic        msrRead = 1'b0;
  logic        charTick = 1'b0;
  logic        idRead = 1'b0;
  logic [31:0] idReg;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  bit       mLine, mModem, mTxPend, mTxPrev;
  int       mCnt;

  always #10 clk = ~clk;

  irq_ident_unit i_irq_ident_unit (
    .clk(clk), .rstN(rstN), .fifoMode(fifoMode), .irqEnable(irqEnable),
    .rxErrFlags(rxErrFlags), .lsrRead(lsrRead), .rxLevel(rxLevel),
    .rxTrigger(rxTrigger), .rxPush(rxPush), .rxPop(rxPop), .txLevel(txLevel),
    .modemDelta(modemDelta), .msrRead(msrRead), .charTick(charTick),
    .idRead(idRead), .idReg(idReg), .irqOut(irqOut)
  );

  function automatic bit rxDataNow();
    return fifoMode ? (rxLevel >= rxTrigger) : (rxLevel != 0);
  endfunction

  function automatic bit txCondNow();
    return fifoMode ? (txLevel <= 5'd8) : (txLevel == 0);
  endfunction

  function automatic logic [31:0] expId();
    logic [31:0] v;
    bit to;
    to = (mCnt == 4);
    v = {24'h0, fifoMode, fifoMode, 6'b000001};
    if (mLine && irqEnable[2])                        v[3:0] = 4'b0110;
    else if ((rxDataNow() || to) && irqEnable[0])     v[3:0] = rxDataNow() ? 4'b0100 : 4'b1100;
    else if (mTxPend && irqEnable[1])                 v[3:0] = 4'b0010;
    else if (mModem && irqEnable[3])                  v[3:0] = 4'b0000;
    return v;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic modelEdge();
    bit shownTx, cond;
    shownTx = (expId() & 32'hF) == 32'h2;
    cond = txCondNow();
    if (!fifoMode || rxLevel == 0 || rxPush || rxPop) mCnt = 0;
    else if (charTick && mCnt != 4) mCnt++;
    if (cond && !mTxPrev) mTxPend = 1;
    else if (!cond || (idRead && shownTx)) mTxPend = 0;
    mTxPrev = cond;
    if (rxErrFlags != 0) mLine = 1; else if (lsrRead) mLine = 0;
    if (modemDelta != 0) mModem = 1; else if (msrRead) mModem = 0;
  endtask

  // inputs already driven after a falling edge
  task automatic cycle();
    #1;
    check("R1 R2 R3 R9 idReg", idReg, expId());
    check("R3 irqOut", {31'h0, irqOut}, {31'h0, ~expId()[0]});
    @(posedge clk);
    modelEdge();
    @(negedge clk);
  endtask

  task automatic clearPulses();
    rxErrFlags = '0; lsrRead = 0; rxPush = 0; rxPop = 0;
    modemDelta = '0; msrRead = 0; charTick = 0; idRead = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    #1;
    // R3 reset value
    check("R3 reset idReg", idReg, 32'h00000001);
    check("R3 reset irqOut", {31'h0, irqOut}, 32'h0);
    rstN = 1;
    @(negedge clk);
    mLine = 0; mModem = 0; mTxPend = 0; mTxPrev = 0; mCnt = 0;

    // R4 timeout after four ticks in FIFO mode
    fifoMode = 1; irqEnable = 4'b0001; rxLevel = 5'd3; rxTrigger = 5'd8;
    txLevel = 5'd16; charTick = 1;
    repeat (4) cycle();
    charTick = 0; #1;
    check("R4 timeout word", idReg, 32'h000000CC);
    check("R4 timeout irqOut", {31'h0, irqOut}, 32'h1);
    rxPush = 1; cycle(); rxPush = 0; #1;
    check("R4 timeout cleared by push", idReg, 32'h000000C1);

    // R1 R8 line error over received data
    irqEnable = 4'b1111; rxLevel = 5'd10; rxErrFlags = 5'b00100; cycle();
    rxErrFlags = '0; #1;
    check("R1 line error first", idReg, 32'h000000C6);
    lsrRead = 1; cycle(); lsrRead = 0; #1;
    check("R6 R8 data after line clear", idReg, 32'h000000C4);
    rxLevel = 0; #1;
    check("R3 nothing pending", idReg, 32'h000000C1);
    modemDelta = 4'b0010; cycle(); modemDelta = '0; #1;
    check("R2 R8 modem code", idReg, 32'h000000C0);
    txLevel = 5'd8; cycle(); #1;
    check("R7 tx half empty over modem", idReg, 32'h000000C2);
    idRead = 1; cycle(); idRead = 0; #1;
    check("R7 tx cleared by read", idReg, 32'h000000C0);
    msrRead = 1; cycle(); msrRead = 0; #1;
    check("R8 modem cleared", idReg, 32'h000000C1);
    fifoMode = 0; rxLevel = 5'd1; #1;
    check("R5 R6 single-register data", idReg, 32'h00000004);
    irqEnable = 4'b0000; #1;
    check("R9 all disabled", idReg, 32'h00000001);
    check("R9 irqOut low", {31'h0, irqOut}, 32'h0);
    cycle();

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      clearPulses();
      if ($urandom_range(0, 31) == 0) fifoMode = $urandom_range(0, 1);
      if ($urandom_range(0, 15) == 0) irqEnable = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'hF;
      if ($urandom_range(0, 15) == 0) rxLevel = 5'($urandom_range(0, 16));
      if ($urandom_range(0, 31) == 0) rxTrigger = 5'($urandom_range(1, 16));
      if ($urandom_range(0, 7) == 0) txLevel = 5'($urandom_range(0, 16));
      if ($urandom_range(0, 11) == 0) rxErrFlags = 5'($urandom);
      if ($urandom_range(0, 11) == 0) modemDelta = 4'($urandom);
      lsrRead  = ($urandom_range(0, 7) == 0);
      msrRead  = ($urandom_range(0, 7) == 0);
      idRead   = ($urandom_range(0, 3) == 0);
      charTick = ($urandom_range(0, 1) == 0);
      rxPush   = ($urandom_range(0, 19) == 0);
      rxPop    = ($urandom_range(0, 19) == 0);
      cycle();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule